// File: doc/BRIEF.md
# XOR Delta-State Register Peripheral

This peripheral keeps a state word as two registers: a reference value and an accumulator of XOR deltas. The state is never copied. Whenever it is asked for, it is rebuilt as the reference XOR the accumulator. Because XOR is commutative and self-inverse, producers can send deltas in any order and get the same result. Sending the same delta twice removes it. A single swap access returns the current state and empties the accumulator in one indivisible step.

A CPU reaches the block through a simple request/ready bus in its own clock domain. The reference and accumulator live in a separate core clock domain that may be asynchronous to the bus.

- A request latches its decoded operation and write data into holding registers.
- It then flips a request toggle, which a synchronizer carries into the core domain.
- The core performs the operation in one cycle, registers the response word and flips an acknowledge toggle.
- That toggle is synchronized back to the bus domain.
- The bus side holds `bus_ready` low, stalling the CPU, until the two toggles agree again. It then presents the response for one cycle.

Top module: `xstate_periph`

## Requirements
- R1: After reset the reference and the accumulator are both zero, so a first state read returns zero, and `bus_ready` is low.
- R2: A write to byte offset 0x00 sets the reference to the write data and clears the accumulator to zero. Its response data is zero.
- R3: A write to byte offset 0x04 XORs the write data into the accumulator and leaves the reference unchanged. Its response data is zero.
- R4: A read of byte offset 0x08 returns the reference XOR the accumulator and changes neither register. For example, a load of 0xDEADBEEF followed by a delta of 0x000000FF reads back 0xDEADBE10.
- R5: A read of byte offset 0x0C returns the reference XOR the accumulator as it stood before the access, and leaves the accumulator zero afterwards. No other request can fall between the read and the clear.
- R6: The read-back state depends only on the set of deltas applied since the last load, not on their order. A delta applied an even number of times has no effect.
- R7: An access with no effect returns zero and changes neither register. This covers:
  - a write to offset 0x08 or 0x0C;
  - a read of offset 0x00 or 0x04;
  - any address with a non-zero bit outside bits [3:2].
- R8: Each accepted request is answered by `bus_ready` high for exactly one bus clock cycle, at least two cycles after acceptance. `bus_rdata` is valid in that cycle. A request is accepted on a bus clock edge where `bus_valid` is high and no request is outstanding. The requester holds `bus_valid`, `bus_write`, `bus_addr` and `bus_wdata` until it sees `bus_ready`. The captured operation and data stay stable until the response is given.
- R9: `bus_ready` is never high while no request is outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_clk | input | 1 | Bus (CPU side) clock |
| bus_rst_n | input | 1 | Active-low reset, bus domain |
| core_clk | input | 1 | Operation core clock, asynchronous to bus_clk |
| core_rst_n | input | 1 | Active-low reset, core domain |
| bus_valid | input | 1 | Request present |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset from the block base |
| bus_wdata | input | DATA_W | Write data (reference or delta) |
| bus_ready | output | 1 | One-cycle completion strobe |
| bus_rdata | output | DATA_W | Response data, valid while bus_ready is high |

## Verification
The hardest situation to reach is a request that arrives while the two toggles and their synchronizers sit at every possible phase of one clock against the other. The swap must land in that window with a delta just ahead of it and a read right behind it. The bench runs the core clock at a period unrelated to the bus period, so the phase drifts on its own. It issues long runs of back-to-back requests: each request starts one cycle after the previous response ends. The stream mixes loads, deltas, swaps, reads and misaligned or out-of-window addresses. A behavioural model of the reference and accumulator predicts every response word.

// File: rtl/xstate_pkg.sv
package xstate_pkg;

   // Operation decoded in the bus domain and held across the crossing
   typedef enum logic [2:0] {
      XS_NOP   = 3'd0,
      XS_LOAD  = 3'd1,
      XS_ACCUM = 3'd2,
      XS_READ  = 3'd3,
      XS_SWAP  = 3'd4
   } xs_op_e;

   // Word slot selected by address bits [3:2]
   localparam logic [1:0] SLOT_LOAD  = 2'd0;
   localparam logic [1:0] SLOT_ACCUM = 2'd1;
   localparam logic [1:0] SLOT_READ  = 2'd2;
   localparam logic [1:0] SLOT_SWAP  = 2'd3;

   function automatic xs_op_e xs_pick(input logic wr, input logic [1:0] slot);
      xs_op_e op;
      unique case (slot)
         SLOT_LOAD:  op = wr ? XS_LOAD  : XS_NOP;
         SLOT_ACCUM: op = wr ? XS_ACCUM : XS_NOP;
         SLOT_READ:  op = wr ? XS_NOP   : XS_READ;
         default:    op = wr ? XS_NOP   : XS_SWAP;
      endcase
      return op;
   endfunction

endpackage

// File: rtl/xstate_sync.sv
module xstate_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);

   if (STAGES < 2) begin : g_bad_stages
      $error("xstate_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '0;
      else        chain_q <= {chain_q[STAGES-2:0], d};
   end

   assign q = chain_q[STAGES-1];

endmodule

// File: rtl/xstate_bus_port.sv
module xstate_bus_port
   import xstate_pkg::*;
#(
   parameter int ADDR_W = 4,
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   input  logic              ack_sync,
   input  logic [DATA_W-1:0] core_result,
   output logic              req_ready,
   output logic [DATA_W-1:0] req_rdata,
   output logic              req_tgl,
   output xs_op_e            hold_op,
   output logic [DATA_W-1:0] hold_wdata
);

   localparam int SLOT_LSB = 2;
   localparam int SLOT_MSB = 3;

   if (ADDR_W < SLOT_MSB + 1) begin : g_bad_addr
      $error("xstate_bus_port: ADDR_W must cover bits [3:2]");
   end

   typedef enum logic [1:0] {ST_IDLE, ST_WAIT, ST_RESP} bus_st_e;

   bus_st_e st_q;
   logic    in_window;
   xs_op_e  op_now;

   // Address must be word aligned and inside the four-word window
   if (ADDR_W > SLOT_MSB + 1) begin : g_wide_addr
      assign in_window = (req_addr[ADDR_W-1:SLOT_MSB+1] == '0) &&
                         (req_addr[SLOT_LSB-1:0] == '0);
   end else begin : g_narrow_addr
      assign in_window = (req_addr[SLOT_LSB-1:0] == '0);
   end

   assign op_now = in_window ? xs_pick(req_write, req_addr[SLOT_MSB:SLOT_LSB]) : XS_NOP;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q       <= ST_IDLE;
         req_tgl    <= 1'b0;
         hold_op    <= XS_NOP;
         hold_wdata <= '0;
         req_rdata  <= '0;
      end else begin
         unique case (st_q)
            ST_IDLE: if (req_valid) begin
               hold_op    <= op_now;
               hold_wdata <= req_wdata;
               req_tgl    <= ~req_tgl;
               st_q       <= ST_WAIT;
            end
            ST_WAIT: if (ack_sync == req_tgl) begin
               req_rdata <= core_result;
               st_q      <= ST_RESP;
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   assign req_ready = (st_q == ST_RESP);

   // R8
   ready_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |=> !req_ready);

   // R8
   hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_WAIT) |=> ($stable(hold_op) && $stable(hold_wdata) && $stable(req_tgl)));

   // R9
   ready_after_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> (ack_sync == req_tgl));

endmodule

// File: rtl/xstate_engine.sv
module xstate_engine
   import xstate_pkg::*;
#(
   parameter int DATA_W      = 32,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_tgl_async,
   input  xs_op_e            hold_op,
   input  logic [DATA_W-1:0] hold_wdata,
   output logic              ack_tgl,
   output logic [DATA_W-1:0] result
);

   logic              req_s;
   logic              exec;
   logic [DATA_W-1:0] ref_q;
   logic [DATA_W-1:0] acc_q;
   logic [DATA_W-1:0] state_now;

   xstate_sync #(.STAGES(SYNC_STAGES)) u_req_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (req_tgl_async),
      .q     (req_s)
   );

   assign exec      = req_s ^ ack_tgl;
   assign state_now = ref_q ^ acc_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ack_tgl <= 1'b0;
         ref_q   <= '0;
         acc_q   <= '0;
         result  <= '0;
      end else if (exec) begin
         ack_tgl <= req_s;
         unique case (hold_op)
            XS_LOAD: begin
               ref_q  <= hold_wdata;
               acc_q  <= '0;
               result <= '0;
            end
            XS_ACCUM: begin
               acc_q  <= acc_q ^ hold_wdata;
               result <= '0;
            end
            XS_READ:  result <= state_now;
            XS_SWAP: begin
               result <= state_now;
               acc_q  <= '0;
            end
            default:  result <= '0;
         endcase
      end
   end

   // R2
   load_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (exec && hold_op == XS_LOAD) |=> (ref_q == $past(hold_wdata) && acc_q == '0));

   // R3
   accum_fold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (exec && hold_op == XS_ACCUM) |=> (acc_q == ($past(acc_q) ^ $past(hold_wdata)) && $stable(ref_q)));

   // R4
   read_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (exec && hold_op == XS_READ) |=> ($stable(ref_q) && $stable(acc_q) &&
                                        result == ($past(ref_q) ^ $past(acc_q))));

   // R5
   swap_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (exec && hold_op == XS_SWAP) |=> (acc_q == '0 && $stable(ref_q) &&
                                        result == ($past(ref_q) ^ $past(acc_q))));

   // R7
   nop_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!exec || hold_op == XS_NOP) |=> ($stable(ref_q) && $stable(acc_q)));

endmodule

// File: rtl/xstate_periph.sv
module xstate_periph
   import xstate_pkg::*;
#(
   parameter int ADDR_W      = 4,
   parameter int DATA_W      = 32,
   parameter int SYNC_STAGES = 2
) (
   input  logic              bus_clk,
   input  logic              bus_rst_n,
   input  logic              core_clk,
   input  logic              core_rst_n,
   input  logic              bus_valid,
   input  logic              bus_write,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic              bus_ready,
   output logic [DATA_W-1:0] bus_rdata
);

   if (DATA_W < 1) begin : g_bad_data
      $error("xstate_periph: DATA_W must be positive");
   end

   logic              req_tgl;
   logic              ack_tgl;
   logic              ack_sync;
   xs_op_e            hold_op;
   logic [DATA_W-1:0] hold_wdata;
   logic [DATA_W-1:0] core_result;

   xstate_bus_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_port (
      .clk         (bus_clk),
      .rst_n       (bus_rst_n),
      .req_valid   (bus_valid),
      .req_write   (bus_write),
      .req_addr    (bus_addr),
      .req_wdata   (bus_wdata),
      .ack_sync    (ack_sync),
      .core_result (core_result),
      .req_ready   (bus_ready),
      .req_rdata   (bus_rdata),
      .req_tgl     (req_tgl),
      .hold_op     (hold_op),
      .hold_wdata  (hold_wdata)
   );

   xstate_sync #(.STAGES(SYNC_STAGES)) u_ack_sync (
      .clk   (bus_clk),
      .rst_n (bus_rst_n),
      .d     (ack_tgl),
      .q     (ack_sync)
   );

   xstate_engine #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) u_engine (
      .clk           (core_clk),
      .rst_n         (core_rst_n),
      .req_tgl_async (req_tgl),
      .hold_op       (hold_op),
      .hold_wdata    (hold_wdata),
      .ack_tgl       (ack_tgl),
      .result        (core_result)
   );

endmodule

// File: tb/xstate_periph_test.sv
module xstate_periph_test;

   localparam int AW = 6;
   localparam int DW = 32;

   logic          bus_clk = 1'b0;
   logic          core_clk = 1'b0;
   logic          bus_rst_n = 1'b0;
   logic          core_rst_n = 1'b0;
   logic          bus_valid = 1'b0;
   logic          bus_write = 1'b0;
   logic [AW-1:0] bus_addr = '0;
   logic [DW-1:0] bus_wdata = '0;
   logic          bus_ready;
   logic [DW-1:0] bus_rdata;

   int  checks = 0;
   int  failures = 0;
   bit  in_xfer = 1'b0;
   bit  mon_on = 1'b0;
   bit  done = 1'b0;

   logic [DW-1:0] mref = '0;
   logic [DW-1:0] macc = '0;

   always #5   bus_clk  = ~bus_clk;
   always #3.5 core_clk = ~core_clk;

   xstate_periph #(.ADDR_W(AW), .DATA_W(DW)) uut (
      .bus_clk    (bus_clk),
      .bus_rst_n  (bus_rst_n),
      .core_clk   (core_clk),
      .core_rst_n (core_rst_n),
      .bus_valid  (bus_valid),
      .bus_write  (bus_write),
      .bus_addr   (bus_addr),
      .bus_wdata  (bus_wdata),
      .bus_ready  (bus_ready),
      .bus_rdata  (bus_rdata)
   );

   task automatic chk(input bit ok, input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic finish_up();
      if (!done) begin
         done = 1'b1;
         $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   endtask

   // Behavioural model: returns expected response, updates model state
   function automatic logic [DW-1:0] model(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] d);
      logic [DW-1:0] r;
      r = '0;
      if (a[AW-1:4] == '0 && a[1:0] == 2'b00) begin
         case (a[3:2])
            2'd0: if (wr)  begin mref = d; macc = '0; end
            2'd1: if (wr)  macc = macc ^ d;
            2'd2: if (!wr) r = mref ^ macc;
            default: if (!wr) begin r = mref ^ macc; macc = '0; end
         endcase
      end
      return r;
   endfunction

   // One bus transfer, compared against the model
   task automatic xfer(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] d, input string req);
      int lat;
      logic [DW-1:0] exp;
      exp = model(wr, a, d);
      @(negedge bus_clk);
      in_xfer   = 1'b1;
      bus_valid = 1'b1;
      bus_write = wr;
      bus_addr  = a;
      bus_wdata = d;
      lat = 0;
      do begin
         @(negedge bus_clk);
         lat++;
      end while (!bus_ready && lat < 2000);
      chk(bus_ready == 1'b1, "R8 ready timeout", {31'd0, bus_ready}, 32'd1);
      chk(lat >= 2, "R8 latency", lat, 32'd2);
      chk(bus_rdata == exp, req, bus_rdata, exp);
      bus_valid = 1'b0;
      bus_wdata = $urandom;
      @(negedge bus_clk);
      chk(bus_ready == 1'b0, "R8 single-cycle ready", {31'd0, bus_ready}, 32'd0);
      in_xfer = 1'b0;
   endtask

   // R9: every bus clock, no ready without an outstanding request
   always @(negedge bus_clk) begin
      if (mon_on && !in_xfer)
         chk(bus_ready == 1'b0, "R9 idle ready", {31'd0, bus_ready}, 32'd0);
   end

   initial begin
      #1_500_000;
      failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      finish_up();
   end

   initial begin
      logic [DW-1:0] s1;
      repeat (5) @(negedge bus_clk);
      bus_rst_n  = 1'b1;
      core_rst_n = 1'b1;
      @(negedge bus_clk);
      mon_on = 1'b1;

      // R1
      chk(bus_ready == 1'b0, "R1 ready after reset", {31'd0, bus_ready}, 32'd0);
      xfer(1'b0, 6'h08, '0, "R1 reset state");

      // R2 R3 R4
      xfer(1'b1, 6'h00, 32'hDEADBEEF, "R2 load");
      xfer(1'b1, 6'h04, 32'h000000FF, "R3 accum");
      xfer(1'b0, 6'h08, '0, "R4 read DEADBE10");
      chk(mref ^ macc == 32'hDEADBE10, "R4 model", mref ^ macc, 32'hDEADBE10);
      xfer(1'b0, 6'h08, '0, "R4 read unchanged");

      // R6 order independence
      xfer(1'b1, 6'h00, 32'h12345678, "R2 load");
      xfer(1'b1, 6'h04, 32'h0F0F0000, "R6 delta a");
      xfer(1'b1, 6'h04, 32'h00003C3C, "R6 delta b");
      xfer(1'b0, 6'h08, '0, "R6 order ab");
      s1 = mref ^ macc;
      xfer(1'b1, 6'h00, 32'h12345678, "R2 load");
      xfer(1'b1, 6'h04, 32'h00003C3C, "R6 delta b");
      xfer(1'b1, 6'h04, 32'h0F0F0000, "R6 delta a");
      xfer(1'b0, 6'h08, '0, "R6 order ba");
      chk((mref ^ macc) == s1, "R6 same result", mref ^ macc, s1);
      xfer(1'b1, 6'h04, 32'hA5A5A5A5, "R6 cancel 1");
      xfer(1'b1, 6'h04, 32'hA5A5A5A5, "R6 cancel 2");
      xfer(1'b0, 6'h08, '0, "R6 cancelled");

      // R5 swap then read shows reference only
      xfer(1'b1, 6'h04, 32'h00FF00FF, "R3 accum");
      xfer(1'b0, 6'h0C, '0, "R5 swap");
      xfer(1'b0, 6'h08, '0, "R5 acc cleared");
      xfer(1'b0, 6'h0C, '0, "R5 swap empty");

      // R2 load clears accumulator
      xfer(1'b1, 6'h04, 32'hFFFF0000, "R3 accum");
      xfer(1'b1, 6'h00, 32'hCAFEF00D, "R2 load");
      xfer(1'b0, 6'h08, '0, "R2 acc cleared");

      // R7 no-effect accesses
      xfer(1'b1, 6'h04, 32'h11111111, "R3 accum");
      xfer(1'b1, 6'h08, 32'hFFFFFFFF, "R7 write read slot");
      xfer(1'b1, 6'h0C, 32'hFFFFFFFF, "R7 write swap slot");
      xfer(1'b0, 6'h00, '0, "R7 read load slot");
      xfer(1'b0, 6'h04, '0, "R7 read accum slot");
      xfer(1'b1, 6'h01, 32'h0BADBAD0, "R7 misaligned load");
      xfer(1'b1, 6'h14, 32'h0BADBAD0, "R7 out of window accum");
      xfer(1'b0, 6'h2C, '0, "R7 out of window swap");
      xfer(1'b0, 6'h08, '0, "R7 state kept");

      // Mixed back-to-back stream
      for (int i = 0; i < 400; i++) begin
         logic [AW-1:0] a;
         bit wr;
         a  = {2'b00, 2'($urandom_range(0, 3)), 2'b00};
         if ($urandom_range(0, 9) == 0) a = AW'($urandom);
         wr = ($urandom_range(0, 1) == 1);
         xfer(wr, a, $urandom, "R4 R5 random stream");
      end

      finish_up();
   end

endmodule